// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one table of 2-bit saturating counters and a global shift register holding the outcomes of recently resolved branches. The table index is the low bits of the branch address XORed with that global history. The table has no tags, so branches whose indices collide share a counter. A lookup takes a branch address and returns a direction in the same cycle. It also returns the history value that the lookup used.

The front end keeps that history snapshot with the branch. When the branch resolves, it sends the address, the snapshot and the real outcome back on the training port. The block rebuilds the index from the snapshot, so it trains the same counter the lookup read, even after the live history has moved on. Each training request also shifts the real outcome into the live history.

The table size and the history length are parameters. A history length of zero turns the block into a plain address-indexed two-bit predictor.

Top module: `gshare_predictor`

## Requirements
- R1: After a synchronous active-high reset, every counter holds weak not-taken (01) and the global history is all zeros. Any lookup then returns not-taken and `pred_hist` reads 0.
- R2: `pred_taken` responds in the same cycle as `pred_pc`. It equals the upper bit of the counter at index `pred_pc[IDX_W-1:0]` XOR the history. The history is zero-extended, so history bit 0 lines up with index bit 0 and the upper index bits come from the address alone.
- R3: A training request (`upd_valid`=1) at a clock edge shifts the history left by one. `upd_taken` enters bit 0 (1 = taken) and the oldest bit is dropped. `pred_hist` shows the live history.
- R4: The history does not change in any cycle without a training request.
- R5: Training goes to index `upd_pc[IDX_W-1:0]` XOR `upd_hist`. The live history has no part in choosing the trained entry.
- R6: A taken outcome raises the trained counter by one, saturating at 11. A not-taken outcome lowers it by one, saturating at 00.
- R7: A counter in a strong state (00 or 11) needs two opposite outcomes in a row before its predicted direction changes.
- R8: Entries carry no address tag. Two addresses that map to the same index read and train one shared counter.
- R9: With `HIST_W` = 0 the index is the address bits alone. `upd_hist` is ignored and the one-bit `pred_hist` stays 0.
- R10: If a lookup and a training request hit the same entry in one cycle, the lookup returns the counter value from before training. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | max(HIST_W,1) | Live global history (snapshot to return with training) |
| upd_valid | input | 1 | Training request this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | max(HIST_W,1) | History snapshot taken at lookup time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup is purely combinational, so `pred_taken` is due in the cycle its address is applied. A training request changes the counter and the history at the next rising edge, so both become visible in the following cycle. The bench drives every input just after a falling edge and samples one time unit later, before the next rising edge. Its reference counters and history are advanced once per edge, just before the next sample, so each comparison sees exactly the state after the edges that have passed. The same-cycle case (R10) is checked before that edge and again after it.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    // Two-bit direction counter; upper bit is the predicted direction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET_VAL = CTR_WEAK_NT;
    localparam int   HIST_MAX      = 10;

    function automatic logic ctr_taken(input ctr_e c);
        return c[1];
    endfunction

    // Saturating step toward the resolved outcome.
    function automatic ctr_e ctr_train(input ctr_e c, input logic taken);
        ctr_e n;
        unique case (c)
            CTR_STRONG_NT: n = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   n = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    n = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            default:       n = taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
    parameter int HIST_W = 8,
    parameter int HB     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HB-1:0] hist_o
);

    generate
        if (HIST_W == 0) begin : g_none
            logic unused_hist_in;
            assign unused_hist_in = ^{clk, rst, shift_en, bit_in};
            assign hist_o = '0;
        end else begin : g_shift
            logic [HB-1:0] hist_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= (hist_q << 1) | HB'(bit_in);
                end
            end
            assign hist_o = hist_q;
        end
    endgenerate

endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 8,
    parameter int HB     = 8
) (
    input  logic [IDX_W-1:0] pc_lo,
    input  logic [HB-1:0]    hist,
    output logic [IDX_W-1:0] idx
);

    generate
        if (HIST_W == 0) begin : g_addr_only
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx = pc_lo;
        end else begin : g_xor
            // History lands on the low index bits; upper bits stay address-only.
            assign idx = pc_lo ^ IDX_W'(hist);
        end
    endgenerate

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
    import gshare_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_e             wr_cur
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_e tbl [DEPTH];

    assign rd_ctr = tbl[rd_idx];
    assign wr_cur = tbl[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_RESET_VAL;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_train(wr_cur, wr_taken);
        end
    end

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [PC_W-1:0]                     pred_pc,
    output logic                                pred_taken,
    output logic [((HIST_W > 0) ? HIST_W : 1)-1:0] pred_hist,
    input  logic                                upd_valid,
    input  logic [PC_W-1:0]                     upd_pc,
    input  logic [((HIST_W > 0) ? HIST_W : 1)-1:0] upd_hist,
    input  logic                                upd_taken
);

    // Supported range: 0 <= HIST_W <= min(IDX_W, HIST_MAX), PC_W > IDX_W.
    localparam int HB = (HIST_W > 0) ? HIST_W : 1;

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    ctr_e             rd_ctr;
    ctr_e             wr_cur;

    logic unused_pc_hi;
    assign unused_pc_hi = ^{pred_pc[PC_W-1:IDX_W], upd_pc[PC_W-1:IDX_W]};

    gshare_hist #(.HIST_W(HIST_W), .HB(HB)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist_o   (pred_hist)
    );

    gshare_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .HB(HB)) u_rd_index (
        .pc_lo (pred_pc[IDX_W-1:0]),
        .hist  (pred_hist),
        .idx   (rd_idx)
    );

    gshare_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .HB(HB)) u_wr_index (
        .pc_lo (upd_pc[IDX_W-1:0]),
        .hist  (upd_hist),
        .idx   (wr_idx)
    );

    gshare_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken),
        .wr_cur   (wr_cur)
    );

    assign pred_taken = ctr_taken(rd_ctr);

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
    parameter int HIST_W = 8,
    parameter int HB     = 8,
    parameter int IDX_W  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic [HB-1:0]    pred_hist,
    input logic [IDX_W-1:0] upd_idx,
    input logic [1:0]       upd_ctr
);

    // R1: history reads zero right after a reset cycle
    a_r1_hist_cleared: assert property (@(posedge clk)
        rst |=> pred_hist == '0);

    // R4: no training request, no history movement
    a_r4_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(pred_hist));

    generate
        if (HIST_W == 0) begin : g_no_hist
            // R9: without history the output stays zero
            a_r9_no_history: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> pred_hist == '0);
        end else begin : g_hist
            // R3: outcome enters at bit 0, older bits move up
            a_r3_hist_shift: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> pred_hist == HB'({$past(pred_hist), $past(upd_taken)}));
        end
    endgenerate

    // R6: back-to-back taken training of one entry never lowers it and only holds at 11
    a_r6_ctr_up: assert property (@(posedge clk) disable iff (rst)
        $past(upd_valid && upd_taken) && upd_valid && upd_idx == $past(upd_idx)
        |-> upd_ctr >= $past(upd_ctr) && (upd_ctr != $past(upd_ctr) || upd_ctr == 2'b11));

    // R6: back-to-back not-taken training of one entry never raises it and only holds at 00
    a_r6_ctr_down: assert property (@(posedge clk) disable iff (rst)
        $past(upd_valid && !upd_taken) && upd_valid && upd_idx == $past(upd_idx)
        |-> upd_ctr <= $past(upd_ctr) && (upd_ctr != $past(upd_ctr) || upd_ctr == 2'b00));

endmodule

bind gshare_predictor gshare_predictor_chk #(
    .HIST_W (HIST_W),
    .HB     (HB),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .pred_hist (pred_hist),
    .upd_idx   (wr_idx),
    .upd_ctr   (wr_cur)
);

// File: tb/gshare_predictor_bench.sv
module gshare_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 32;
    localparam int IDX_W  = 10;
    localparam int HIST_W = 8;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int B_PC_W = 16;
    localparam int B_IDX  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [PC_W-1:0]   pred_pc   = '0;
    logic              pred_taken;
    logic [HIST_W-1:0] pred_hist;
    logic              upd_valid = 1'b0;
    logic [PC_W-1:0]   upd_pc    = '0;
    logic [HIST_W-1:0] upd_hist  = '0;
    logic              upd_taken = 1'b0;

    logic [B_PC_W-1:0] b_pred_pc   = '0;
    logic              b_pred_taken;
    logic [0:0]        b_pred_hist;
    logic              b_upd_valid = 1'b0;
    logic [B_PC_W-1:0] b_upd_pc    = '0;
    logic [0:0]        b_upd_hist  = '0;
    logic              b_upd_taken = 1'b0;

    gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_gshare_predictor (
        .clk(clk), .rst(rst),
        .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_hist(pred_hist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken)
    );

    gshare_predictor #(.PC_W(B_PC_W), .IDX_W(B_IDX), .HIST_W(0)) u_gshare_predictor_bimodal (
        .clk(clk), .rst(rst),
        .pred_pc(b_pred_pc), .pred_taken(b_pred_taken), .pred_hist(b_pred_hist),
        .upd_valid(b_upd_valid), .upd_pc(b_upd_pc), .upd_hist(b_upd_hist), .upd_taken(b_upd_taken)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference state, built from the requirements
    logic [1:0]        m_tbl [DEPTH];
    logic [HIST_W-1:0] m_hist;
    bit                p_v;
    logic [IDX_W-1:0]  p_idx;
    bit                p_t;

    function automatic logic [IDX_W-1:0] mdl_idx(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
        return pc[IDX_W-1:0] ^ {{(IDX_W-HIST_W){1'b0}}, h};
    endfunction

    function automatic logic [1:0] mdl_step(input logic [1:0] c, input bit t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = 2'b01;
        m_hist = '0;
        p_v = 1'b0;
    endtask

    task automatic commit();
        if (p_v) begin
            m_tbl[p_idx] = mdl_step(m_tbl[p_idx], p_t);
            m_hist = {m_hist[HIST_W-2:0], p_t};
        end
        p_v = 1'b0;
    endtask

    // Drive one cycle; when xh is set, the low address bits are XORed with the
    // reference history so that ppc[IDX_W-1:0] names the table entry looked up.
    task automatic step(input logic [PC_W-1:0] ppc, input bit xh, input bit uv,
                        input logic [PC_W-1:0] upc, input logic [HIST_W-1:0] uh, input bit ut);
        commit();
        @(negedge clk);
        pred_pc   = xh ? {ppc[PC_W-1:IDX_W], mdl_idx(ppc, m_hist)} : ppc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_hist  = uh;
        upd_taken = ut;
        #1;
        p_v   = uv;
        p_idx = mdl_idx(upc, uh);
        p_t   = ut;
    endtask

    task automatic look(input logic [PC_W-1:0] e);
        step(e, 1'b1, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic train(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h, input bit t);
        step('0, 1'b1, 1'b1, pc, h, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [HIST_W-1:0] h0;
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        look(32'd5);
        check("R1 pred_taken", pred_taken, 0);
        check("R1 pred_hist", pred_hist, 0);
        for (int i = 0; i < 4; i++) begin
            step($urandom, 1'b0, 1'b0, '0, '0, 1'b0);
            check("R1 random pc", pred_taken, 0);
        end

        // R6/R7 on entry 5, trained with snapshot 0
        train(32'd5, 8'h00, 1'b1);
        look(32'd5);  check("R6 01->10 taken", pred_taken, 1);
        check("R3 history after one taken", pred_hist, 8'h01);
        train(32'd5, 8'h00, 1'b1);
        train(32'd5, 8'h00, 1'b1);
        train(32'd5, 8'h00, 1'b0);
        look(32'd5);  check("R7 one miss from strong keeps taken", pred_taken, 1);
        check("R3 history pattern", pred_hist, 8'h0E);
        train(32'd5, 8'h00, 1'b0);
        look(32'd5);  check("R7 second miss flips", pred_taken, 0);
        train(32'd5, 8'h00, 1'b0);
        train(32'd5, 8'h00, 1'b0);
        train(32'd5, 8'h00, 1'b1);
        look(32'd5);  check("R6 saturate at 00", pred_taken, 0);
        train(32'd5, 8'h00, 1'b1);
        look(32'd5);  check("R6 climb after floor", pred_taken, 1);

        // R4: idle cycles hold history
        h0 = pred_hist;
        look(32'd5); look(32'd5);
        check("R4 history held", pred_hist, h0);

        // R5: training index from snapshot, not live history
        train(32'h3, 8'h03, 1'b1);
        look(32'd0);  check("R5 trained entry 0", pred_taken, 1);
        look(32'd3);  check("R5 entry 3 untouched", pred_taken, 0);

        // R8: aliasing addresses share a counter
        train(32'h0000_0407, 8'h00, 1'b1);
        look(32'hABC0_0007); check("R8 alias shares counter", pred_taken, 1);

        // R10: same-cycle lookup and training of entry 9
        step(32'd9, 1'b1, 1'b1, 32'd9, 8'h00, 1'b1);
        check("R10 pre-update value", pred_taken, 0);
        look(32'd9);  check("R10 post-update value", pred_taken, 1);

        // R2/R3: random traffic against the reference
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] ppc, upc;
            logic [HIST_W-1:0] uh;
            ppc = ($urandom & 32'hFFFF_F000) | ($urandom % 48);
            upc = ($urandom & 32'hFFFF_F000) | ($urandom % 48);
            uh  = ($urandom % 2) ? m_hist : HIST_W'($urandom);
            step(ppc, 1'b0, ($urandom % 4) != 0, upc, uh, ($urandom % 3) != 0);
            check("R2 random prediction", pred_taken, m_tbl[mdl_idx(ppc, m_hist)][1]);
            check("R3 random history", pred_hist, m_hist);
        end
        step('0, 1'b0, 1'b0, '0, '0, 1'b0);

        // R9: zero-length history instance
        @(negedge clk);
        b_pred_pc = 16'h0005;
        #1 check("R9 initial not-taken", b_pred_taken, 0);
        b_upd_valid = 1'b1; b_upd_pc = 16'h0045; b_upd_hist = 1'b1; b_upd_taken = 1'b1;
        @(negedge clk);
        @(negedge clk);
        b_upd_valid = 1'b0;
        #1;
        check("R9 address-only index", b_pred_taken, 1);
        check("R9 history stays zero", b_pred_hist, 0);
        b_pred_pc = 16'h0006;
        #1 check("R9 neighbour entry untouched", b_pred_taken, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule